// File: doc/BRIEF.md
# Fractional Microsecond Tick Prescaler

This block takes a fast reference clock and makes two things from it: a one-cycle tick enable that fires at an average rate of 1 MHz, and a free-running microsecond up-counter that advances once per tick. The rate comes from a programmable ratio. One byte of the configuration gives the number of ticks, and the other byte gives the number of reference cycles those ticks are spread across. Both bytes are stored minus one. This lets references such as 12.8, 16.8, 19.2 or 38.4 MHz produce an exact 1 MHz average, even though they are not integer multiples of it.

The ratio is produced by an accumulator. On every reference cycle it adds the tick count. Whenever the sum reaches the cycle count, it subtracts the cycle count and emits one tick. Software uses a small register bus to do four things: set the ratio, read the counter, read back the configuration, and freeze the counter. The configuration may be rewritten at any time, for example after a power-state resume. Each such write restarts the accumulator from zero.

Top module: `usec_tick_gen`

## Requirements
- R1: After reset, `usec_count` is 0 and `tick_1us` is 0. A read of the ratio register returns the parameter `CFG_RST` (default 0x000b). A read of the freeze register returns 0.
- R2: The ratio register sits at byte offset 0x14 and is 16 bits wide. Bits 15:8 hold T-1 and bits 7:0 hold C-1. When T < C, exactly floor(N*T/C) ticks are emitted over the N cycles that follow a ratio write.
- R3: `usec_count` changes only on a clock edge at which `tick_1us` goes high or stays high. At that edge, and while not frozen, it rises by exactly one, so its change over a window equals the number of ticks in that window.
- R4: When T >= C, `tick_1us` is high on every cycle after the write.
- R5: A ratio write clears the accumulator. `tick_1us` is low in the cycle after the write. With T = 1, the first tick appears exactly C cycles after the write edge.
- R6: `usec_count` wraps from all ones to 0. Its width is the parameter `CNT_W`, which defaults to 32.
- R7: Bit 0 of the freeze register at offset 0x4c holds `usec_count` while it is set. Ticks keep being emitted while the counter is frozen.
- R8: Reads are registered, and `bus_rdata` reflects the address of the previous cycle. Offset 0x10 returns the counter, offset 0x14 returns the ratio in bits 15:0, and offset 0x4c returns the freeze bit in bit 0. Every other offset returns 0.
- R9: Writes to the counter offset or to unmapped offsets change neither the counter, the ratio nor the freeze bit.
- R10: When 2*T <= C, two ticks are never emitted on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wr | input | 1 | Write strobe for the current cycle |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data for the previous cycle's address |
| tick_1us | output | 1 | One-cycle tick enable |
| usec_count | output | CNT_W | Microsecond counter |

## Verification
The bench drives several ratios and counts ticks over whole periods: integer ones, fractional ones, a one-to-one ratio and an oversubscribed ratio. An accumulator that dropped or duplicated its carry would show a tick count that is off by one or more. Rewriting the ratio mid-run and timing the first tick catches a design that keeps its old phase, because its first tick would land early. A narrow counter is driven through its wrap, and the freeze bit is set while ticks run, which exposes a counter that saturates or keeps counting. Writes to the counter offset and to unmapped offsets, followed by readback, catch address decode that leaks into state.

// File: rtl/usec_pkg.sv
package usec_pkg;
  localparam logic [7:0]  OFS_COUNT  = 8'h10;
  localparam logic [7:0]  OFS_RATIO  = 8'h14;
  localparam logic [7:0]  OFS_FREEZE = 8'h4c;
  localparam logic [15:0] RATIO_RST  = 16'h000b;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_COUNT,
    SEL_RATIO,
    SEL_FREEZE
  } reg_sel_e;
endpackage

// File: rtl/usec_regs.sv
module usec_regs
  import usec_pkg::*;
#(
  parameter int          ADDR_W  = 8,
  parameter int          DATA_W  = 32,
  parameter int          FRAC_W  = 8,
  parameter int          CNT_W   = 32,
  parameter logic [15:0] CFG_RST = RATIO_RST
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic                  bus_wr,
  input  logic [DATA_W-1:0]     bus_wdata,
  output logic [DATA_W-1:0]     bus_rdata,
  input  logic [CNT_W-1:0]      count,
  output logic [2*FRAC_W-1:0]   ratio,
  output logic                  ratio_load,
  output logic                  freeze
);
  localparam int CFG_W = 2 * FRAC_W;

  reg_sel_e          sel;
  logic [DATA_W-1:0] rd_mux;

  always_comb begin
    if (bus_addr == ADDR_W'(OFS_COUNT))       sel = SEL_COUNT;
    else if (bus_addr == ADDR_W'(OFS_RATIO))  sel = SEL_RATIO;
    else if (bus_addr == ADDR_W'(OFS_FREEZE)) sel = SEL_FREEZE;
    else                                      sel = SEL_NONE;
  end

  assign ratio_load = bus_wr && (sel == SEL_RATIO);

  always_comb begin
    rd_mux = '0;
    case (sel)
      SEL_COUNT:  rd_mux[CNT_W-1:0] = count;
      SEL_RATIO:  rd_mux[CFG_W-1:0] = ratio;
      SEL_FREEZE: rd_mux[0]         = freeze;
      default:    rd_mux            = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ratio     <= CFG_W'(CFG_RST);
      freeze    <= 1'b0;
      bus_rdata <= '0;
    end else begin
      if (ratio_load) ratio <= bus_wdata[CFG_W-1:0];
      if (bus_wr && sel == SEL_FREEZE) freeze <= bus_wdata[0];
      bus_rdata <= rd_mux;
    end
  end

  // R9: ratio changes only through a write to its own offset
  p_ratio_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !ratio_load |=> $stable(ratio));
  // R8: unmapped offsets read as zero
  p_unmapped_zero_r8: assert property (@(posedge clk) disable iff (rst)
    (sel == SEL_NONE) |=> (bus_rdata == '0));
endmodule

// File: rtl/usec_frac_acc.sv
module usec_frac_acc #(
  parameter int FRAC_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                load,
  input  logic [2*FRAC_W-1:0] ratio,
  output logic                tick,
  output logic                tick_nxt
);
  localparam int ACC_W = FRAC_W + 2;

  logic [ACC_W-1:0] acc, acc_nxt, num, den, sum;
  logic             sat;

  assign num = ACC_W'(ratio[2*FRAC_W-1:FRAC_W]) + ACC_W'(1);
  assign den = ACC_W'(ratio[FRAC_W-1:0]) + ACC_W'(1);
  assign sum = acc + num;
  assign sat = (num >= den);

  always_comb begin
    if (load) begin
      acc_nxt  = '0;
      tick_nxt = 1'b0;
    end else if (sat) begin
      acc_nxt  = '0;
      tick_nxt = 1'b1;
    end else if (sum >= den) begin
      acc_nxt  = sum - den;
      tick_nxt = 1'b1;
    end else begin
      acc_nxt  = sum;
      tick_nxt = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc  <= '0;
      tick <= 1'b0;
    end else begin
      acc  <= acc_nxt;
      tick <= tick_nxt;
    end
  end

  // R2: remainder stays below the cycle count
  p_acc_bound_r2: assert property (@(posedge clk) disable iff (rst)
    acc < den);
  // R5: a ratio write silences the next cycle
  p_load_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    load |=> !tick);
  // R4: oversubscribed ratio ticks every cycle
  p_sat_every_r4: assert property (@(posedge clk) disable iff (rst)
    (sat && !load) |=> tick);
  // R10: sparse ratios never tick twice in a row
  p_no_back2back_r10: assert property (@(posedge clk) disable iff (rst)
    (tick && !load && ((num << 1) <= den)) |=> !tick);
endmodule

// File: rtl/usec_counter.sv
module usec_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  input  logic             hold,
  output logic [CNT_W-1:0] count
);
  always_ff @(posedge clk) begin
    if (rst)               count <= '0;
    else if (inc && !hold) count <= count + CNT_W'(1);
  end

  // R7: frozen counter does not move
  p_freeze_hold_r7: assert property (@(posedge clk) disable iff (rst)
    hold |=> $stable(count));
  // R3: no movement without a tick
  p_only_on_tick_r3: assert property (@(posedge clk) disable iff (rst)
    !inc |=> $stable(count));
  // R6: all ones rolls over to zero
  p_wrap_r6: assert property (@(posedge clk) disable iff (rst)
    (count == '1 && inc && !hold) |=> (count == '0));
endmodule

// File: rtl/usec_tick_gen.sv
module usec_tick_gen
  import usec_pkg::*;
#(
  parameter int          ADDR_W  = 8,
  parameter int          DATA_W  = 32,
  parameter int          FRAC_W  = 8,
  parameter int          CNT_W   = 32,
  parameter logic [15:0] CFG_RST = RATIO_RST
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              tick_1us,
  output logic [CNT_W-1:0]  usec_count
);
  logic [2*FRAC_W-1:0] ratio;
  logic                ratio_load, freeze, tick_nxt;

  usec_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .FRAC_W(FRAC_W),
    .CNT_W(CNT_W), .CFG_RST(CFG_RST)
  ) u_regs (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .count(usec_count),
    .ratio(ratio), .ratio_load(ratio_load), .freeze(freeze)
  );

  usec_frac_acc #(.FRAC_W(FRAC_W)) u_acc (
    .clk(clk), .rst(rst), .load(ratio_load), .ratio(ratio),
    .tick(tick_1us), .tick_nxt(tick_nxt)
  );

  usec_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .inc(tick_nxt), .hold(freeze), .count(usec_count)
  );
endmodule

// File: tb/sim_usec_tick_gen.sv
module sim_usec_tick_gen;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 10;
  localparam logic [CW-1:0] CMASK = '1;
  localparam int NVEC = 7;
  // {ratio, window cycles, expected ticks}
  localparam logic [47:0] VECS [NVEC] = '{
    48'h000b_0078_000a, 48'h043f_0080_000a, 48'h04bf_0180_000a,
    48'h0453_00a8_000a, 48'h0000_0014_0014, 48'h0301_000a_000a,
    48'h0102_0009_0006};

  logic clk = 1'b0, rst = 1'b1, bus_wr = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic tick_1us;
  logic [CW-1:0] usec_count;
  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  usec_tick_gen #(.CNT_W(CW)) u0 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tick_1us(tick_1us), .usec_count(usec_count));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a;
    @(posedge clk); @(negedge clk); d = bus_rdata;
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [CW-1:0] c0;
    do_reset();
    chk("R1 count", 32'(usec_count), 0);
    chk("R1 tick", 32'(tick_1us), 0);
    rd(8'h14, d); chk("R1 ratio reset", d, 32'h000b);
    rd(8'h4c, d); chk("R1 freeze reset", d, 0);

    for (int v = 0; v < NVEC; v++) begin
      int n, exp, cnt, b2b;
      logic [15:0] r;
      logic prev;
      r = VECS[v][47:32]; n = int'(VECS[v][31:16]); exp = int'(VECS[v][15:0]);
      wr(8'h14, 32'(r));
      chk("R5 quiet after write", 32'(tick_1us), 0);
      c0 = usec_count; cnt = 0; b2b = 0; prev = 1'b0;
      for (int i = 0; i < n; i++) begin
        step();
        if (tick_1us && prev) b2b++;
        prev = tick_1us;
        if (tick_1us) cnt++;
      end
      if (r[15:8] >= r[7:0]) chk("R4 every cycle", 32'(cnt), 32'(n));
      else chk("R2 tick total", 32'(cnt), 32'(exp));
      chk("R3 count delta", 32'((usec_count - c0) & CMASK), 32'(exp));
      if ((int'(r[15:8]) + 1) * 2 <= int'(r[7:0]) + 1)
        chk("R10 no back-to-back", 32'(b2b), 0);
    end

    // R5: rewrite mid-run, first tick exactly C cycles later
    wr(8'h14, 32'h0000_0007);
    for (int i = 1; i <= 8; i++) begin
      step();
      chk("R5 first tick timing", 32'(tick_1us), (i == 8) ? 1 : 0);
    end

    // R7 freeze with every-cycle ticks
    wr(8'h14, 32'h0000_0000);
    wr(8'h4c, 32'h1);
    c0 = usec_count;
    begin
      int seen = 0;
      for (int i = 0; i < 50; i++) begin step(); if (tick_1us) seen++; end
      chk("R7 counter held", 32'(usec_count), 32'(c0));
      chk("R7 ticks continue", 32'(seen), 50);
    end
    rd(8'h4c, d); chk("R8 freeze readback", d, 1);
    rd(8'h10, d); chk("R8 count readback", d, 32'(c0));
    rd(8'h14, d); chk("R8 ratio readback", d, 0);
    // R9 ignored writes
    wr(8'h10, 32'h155);
    wr(8'h20, 32'hffff_ffff);
    rd(8'h10, d); chk("R9 count write ignored", d, 32'(c0));
    rd(8'h14, d); chk("R9 ratio untouched", d, 0);
    rd(8'h4c, d); chk("R9 freeze untouched", d, 1);
    rd(8'h20, d); chk("R8 unmapped reads zero", d, 0);
    wr(8'h14, 32'hdead_043f);
    rd(8'h14, d); chk("R2 ratio 16-bit field", d, 32'h043f);

    // R6 wrap
    do_reset();
    wr(8'h14, 32'h0000_0000);
    repeat (1030) step();
    chk("R6 wrap", 32'(usec_count), 6);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule